// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous pipelined static RAM whose data bus can switch between reads and writes on consecutive cycles with no idle slot. All inputs are captured on the rising clock edge. Each enabled cycle is decoded as a deselect, the start of a burst read or write at an external address, the continuation of the previous operation at the next burst address, a dummy read (output enable high) or a write abort (no byte enabled). A two-bit burst counter steps the low address bits in linear or interleaved order, selected by a pin.

The read data for a command is driven in the second cycle after that command is captured, and the write data for a command is sampled at the second enabled edge after it, so both kinds of transfer occupy the same bus slot relative to their command. A read whose address matches a write still waiting for its data takes the enabled bytes of that data from the data input bus in the same edge. An active-low clock enable freezes the whole block. The bidirectional data bus is split into an input port, an output port and an output-enable port; the array is a small parameterised register array.

Top module: `zt_sram`

## Requirements
- R1: With `adv` low and the device selected, `rw_n` high starts a read and `rw_n` low starts a write at the word given by `addr`, and the burst count restarts at zero.
- R2: While `cke_n` is high every input is ignored: no array byte changes, `dq_out` and `dq_oe` hold their values, and that edge does not count toward the two-edge write data delay.
- R3: With `adv` low the device is selected only for `ce1_n`=0, `ce2`=1, `ce3_n`=0; every other combination is a deselect that neither writes nor drives the bus.
- R4: A read captured at enabled edge k drives its word on `dq_out` with `dq_oe`=1 from edge k+1 until edge k+2.
- R5: Write data for a command captured at enabled edge k is taken from `dq_in` at enabled edge k+2; byte lane i is `dq_in[8i+7:8i]` and is written only when `bw_n[i]` was 0 in the command cycle.
- R6: A write cycle with all `bw_n` bits high changes no byte of the array, yet the burst address still advances.
- R7: A read cycle with `oe_n` high at capture is a dummy read: `dq_oe` stays 0 in its slot while the burst address advances.
- R8: With `adv` high the cycle repeats the previous operation (read, write or deselect) at the next burst address, and the chip enables and `rw_n` are ignored.
- R9: With `mode`=0 the burst is linear: the two low address bits are the start value plus 0, 1, 2, 3 modulo 4, upper bits unchanged.
- R10: With `mode`=1 the burst is interleaved: the two low address bits are the start value XOR 0, 1, 2, 3.
- R11: Reads and writes may alternate on consecutive cycles; a read of a word written by the immediately preceding write command returns that write's enabled bytes merged over the stored word.
- R12: After reset `dq_oe` is 0, `dq_out` is 0 and the burst state is deselect, so continue cycles issued before any load drive nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| rw_n | input | 1 | 1 = read, 0 = write (load cycles only) |
| bw_n | input | LANES | Byte write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*8 | Data bus, input side |
| dq_out | output | LANES*8 | Data bus, output side |
| dq_oe | output | 1 | Data bus output enable |

## Verification
The assertions watch on every cycle that a stalled edge leaves the outputs untouched, that a deselect load yields no operation, that a burst continuation keeps the operation and steps the counter while a load clears it, that a captured read drives the bus one edge later unless it was a dummy read, and that an abort write or an enabled lane behaves correctly in the array. Only the bench scenarios can show end-to-end data values: the actual linear and interleaved address sequences, byte merging, the two-edge write data timing across a stalled cycle, forwarding between a write and the read right after it, and that ignored chip enables or read/write levels during a continuation leave the array intact.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int ZT_ADDR_W = 6;
    localparam int ZT_LANES  = 2;
    localparam int ZT_LANE_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of burst beat `cnt` starting from `base`.
    function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ileave);
        logic [1:0] r;
        if (ileave) r = base ^ cnt;
        else        r = base + cnt;
        return r;
    endfunction

    function automatic logic chip_selected(input logic c1_n,
                                           input logic c2,
                                           input logic c3_n);
        return (!c1_n) && c2 && (!c3_n);
    endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = ZT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              adv,
    input  logic              sel,
    input  logic              rw_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;
    op_e               last_q;

    assign cnt_nx = cnt_q + 2'd1;

    always_comb begin
        if (!adv) begin
            cur_addr = addr;
            if (!sel)      cur_op = OP_IDLE;
            else if (rw_n) cur_op = OP_READ;
            else           cur_op = OP_WRITE;
        end else begin
            cur_op   = last_q;
            cur_addr = {base_q[ADDR_W-1 -: HI_W], burst_lsb(base_q[1:0], cnt_nx, mode)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            last_q <= OP_IDLE;
        end else if (en) begin
            if (!adv) begin
                base_q <= addr;
                cnt_q  <= 2'd0;
                last_q <= cur_op;
            end else begin
                cnt_q  <= cnt_nx;
            end
        end
    end

    // R1: a load restarts the burst count
    a_r1_load_clears: assert property (@(posedge clk) disable iff (rst)
        en && !adv |=> cnt_q == 2'd0);

    // R8: a continuation keeps the operation type
    a_r8_repeat_op: assert property (@(posedge clk) disable iff (rst)
        en && adv |=> last_q == $past(last_q));

    // R9 / R10: each continuation moves one beat on
    a_r9_beat_step: assert property (@(posedge clk) disable iff (rst)
        en && adv |=> cnt_q == $past(cnt_q) + 2'd1);

    // R2: a stalled edge freezes the burst state
    a_r2_burst_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q) && $stable(base_q) && $stable(last_q));

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              hit;

    assign hit = wr_en && (wr_addr == rd_addr);

    // Per-lane read path: bytes of a write landing in this same edge win.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (hit && wr_lane[g])
                rd_data[g*LANE_W +: LANE_W] = wr_data[g*LANE_W +: LANE_W];
            else
                rd_data[g*LANE_W +: LANE_W] = mem[rd_addr][g*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (en && wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lane[i])
                    mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
            end
        end
    end

    // R6: a write with no lane enabled leaves the word alone
    a_r6_abort_keeps: assert property (@(posedge clk) disable iff (rst)
        en && wr_en && (wr_lane == '0) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));

    // R5: an enabled lane 0 takes the bus byte
    a_r5_lane0_write: assert property (@(posedge clk) disable iff (rst)
        en && wr_en && wr_lane[0] |=>
            mem[$past(wr_addr)][LANE_W-1:0] == $past(wr_data[LANE_W-1:0]));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = ZT_ADDR_W,
    parameter int LANES  = ZT_LANES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cke_n,
    input  logic                  ce1_n,
    input  logic                  ce2,
    input  logic                  ce3_n,
    input  logic                  adv,
    input  logic                  rw_n,
    input  logic [LANES-1:0]      bw_n,
    input  logic                  oe_n,
    input  logic                  mode,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [LANES*8-1:0]    dq_in,
    output logic [LANES*8-1:0]    dq_out,
    output logic                  dq_oe
);

    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
        logic              drive;
    } stage_t;

    logic              en;
    logic              sel;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    stage_t            cur_s, s1_q, s2_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_q;

    assign en  = !cke_n;
    assign sel = chip_selected(ce1_n, ce2, ce3_n);

    zt_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .adv      (adv),
        .sel      (sel),
        .rw_n     (rw_n),
        .mode     (mode),
        .addr     (addr),
        .cur_op   (cur_op),
        .cur_addr (cur_addr)
    );

    always_comb begin
        cur_s.op    = cur_op;
        cur_s.addr  = cur_addr;
        cur_s.lanes = ~bw_n;
        cur_s.drive = !oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '{op: OP_IDLE, addr: '0, lanes: '0, drive: 1'b0};
            s2_q   <= '{op: OP_IDLE, addr: '0, lanes: '0, drive: 1'b0};
            dout_q <= '0;
        end else if (en) begin
            s1_q <= cur_s;
            s2_q <= s1_q;
            if (s1_q.op == OP_READ)
                dout_q <= rd_word;
        end
    end

    zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_en   (s2_q.op == OP_WRITE),
        .wr_addr (s2_q.addr),
        .wr_lane (s2_q.lanes),
        .wr_data (dq_in),
        .rd_addr (s1_q.addr),
        .rd_data (rd_word)
    );

    assign dq_out = dout_q;
    assign dq_oe  = (s2_q.op == OP_READ) && s2_q.drive;

    // R2: a stalled edge leaves the bus outputs unchanged
    a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dq_out) && $stable(dq_oe));

    // R3: a load with a bad enable combination yields no operation
    a_r3_deselect: assert property (@(posedge clk) disable iff (rst)
        en && !adv && !sel |=> s1_q.op == OP_IDLE);

    // R4: a captured driving read reaches the bus on the next enabled edge
    a_r4_read_slot: assert property (@(posedge clk) disable iff (rst)
        en && s1_q.op == OP_READ && s1_q.drive |=> dq_oe);

    // R7: a dummy read never drives the bus
    a_r7_dummy_quiet: assert property (@(posedge clk) disable iff (rst)
        en && s1_q.op == OP_READ && !s1_q.drive |=> !dq_oe);

endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] DES = 3'b110;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke_n, ce1_n, ce2, ce3_n, adv, rw_n, oe_n, mode;
    logic [1:0]  bw_n;
    logic [5:0]  addr;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic        dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    zt_sram u0 (
        .clk(clk), .rst(rst), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adv(adv), .rw_n(rw_n), .bw_n(bw_n), .oe_n(oe_n), .mode(mode), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one command cycle (called at a falling edge), return at the next falling edge.
    task automatic step(input logic s_cke_n, input logic [2:0] s_ce, input logic s_adv,
                        input logic s_rw_n, input logic [1:0] s_bw_n, input logic s_oe_n,
                        input logic [5:0] s_addr, input logic [15:0] s_din);
        cke_n = s_cke_n;
        {ce1_n, ce2, ce3_n} = s_ce;
        adv = s_adv; rw_n = s_rw_n; bw_n = s_bw_n; oe_n = s_oe_n;
        addr = s_addr; dq_in = s_din;
        @(negedge clk);
    endtask

    task automatic ld_wr(input logic [5:0] a, input logic [1:0] b, input logic [15:0] d);
        step(1'b0, SEL, 1'b0, 1'b0, b, 1'b1, a, d);
    endtask

    task automatic ld_rd(input logic [5:0] a, input logic o, input logic [15:0] d);
        step(1'b0, SEL, 1'b0, 1'b1, 2'b11, o, a, d);
    endtask

    task automatic cont(input logic [1:0] b, input logic o, input logic [15:0] d);
        step(1'b0, SEL, 1'b1, 1'b1, b, o, 6'd0, d);
    endtask

    task automatic nop(input logic [15:0] d);
        step(1'b0, DES, 1'b0, 1'b1, 2'b11, 1'b1, 6'd0, d);
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] d);
        ld_wr(a, 2'b00, 16'h0);
        nop(16'h0);
        nop(d);
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [15:0] exp, input string tag);
        ld_rd(a, 1'b0, 16'h0);
        nop(16'h0);
        chk({31'd0, dq_oe}, 32'd1, {tag, " oe"});
        chk({16'd0, dq_out}, {16'd0, exp}, tag);
        nop(16'h0);
    endtask

    task automatic t_reset;
        chk({31'd0, dq_oe}, 32'd0, "R12 oe after reset");
        chk({16'd0, dq_out}, 32'd0, "R12 dout after reset");
        cont(2'b00, 1'b0, 16'h0);
        cont(2'b00, 1'b0, 16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R12 continue after reset");
        cont(2'b00, 1'b0, 16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R12 continue after reset 2");
        nop(16'h0);
    endtask

    task automatic t_linear;
        mode = 1'b0;
        ld_wr(6'h0A, 2'b00, 16'h0);
        cont(2'b00, 1'b1, 16'h0);
        cont(2'b00, 1'b1, 16'hA0A0);
        cont(2'b00, 1'b1, 16'hB1B1);
        nop(16'hC2C2);
        nop(16'hD3D3);
        rd_check(6'h0A, 16'hA0A0, "R1 R9 beat0 0x0A");
        rd_check(6'h0B, 16'hB1B1, "R9 beat1 0x0B");
        rd_check(6'h08, 16'hC2C2, "R9 beat2 wraps 0x08");
        rd_check(6'h09, 16'hD3D3, "R9 beat3 0x09");
        ld_rd(6'h0B, 1'b0, 16'h0);
        cont(2'b11, 1'b0, 16'h0);
        chk({16'd0, dq_out}, 32'h0000B1B1, "R4 R9 read burst 0x0B");
        cont(2'b11, 1'b0, 16'h0);
        chk({16'd0, dq_out}, 32'h0000C2C2, "R9 read burst 0x08");
        cont(2'b11, 1'b0, 16'h0);
        chk({16'd0, dq_out}, 32'h0000D3D3, "R9 read burst 0x09");
        nop(16'h0);
        chk({16'd0, dq_out}, 32'h0000A0A0, "R9 read burst 0x0A");
        nop(16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R4 bus released");
    endtask

    task automatic t_interleave;
        mode = 1'b1;
        ld_wr(6'h15, 2'b00, 16'h0);
        cont(2'b00, 1'b1, 16'h0);
        cont(2'b00, 1'b1, 16'h1515);
        cont(2'b00, 1'b1, 16'h1414);
        nop(16'h1717);
        nop(16'h1616);
        ld_rd(6'h16, 1'b0, 16'h0);
        cont(2'b11, 1'b0, 16'h0);
        chk({16'd0, dq_out}, 32'h00001616, "R10 beat0 0x16");
        cont(2'b11, 1'b0, 16'h0);
        chk({16'd0, dq_out}, 32'h00001717, "R10 beat1 0x17");
        cont(2'b11, 1'b0, 16'h0);
        chk({16'd0, dq_out}, 32'h00001414, "R10 beat2 0x14");
        nop(16'h0);
        chk({16'd0, dq_out}, 32'h00001515, "R10 beat3 0x15");
        nop(16'h0);
        mode = 1'b0;
    endtask

    task automatic t_deselect;
        step(1'b0, 3'b000, 1'b0, 1'b0, 2'b00, 1'b1, 6'h0A, 16'hEEEE);
        step(1'b0, 3'b011, 1'b0, 1'b0, 2'b00, 1'b1, 6'h0A, 16'hEEEE);
        step(1'b0, 3'b110, 1'b0, 1'b0, 2'b00, 1'b1, 6'h0A, 16'hEEEE);
        nop(16'hEEEE);
        nop(16'hEEEE);
        rd_check(6'h0A, 16'hA0A0, "R3 deselect write ignored");
        step(1'b0, 3'b011, 1'b0, 1'b1, 2'b11, 1'b0, 6'h0A, 16'h0);
        nop(16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R3 deselect read not driven");
        nop(16'h0);
    endtask

    task automatic t_bytes;
        write_word(6'h20, 16'h1111);
        ld_wr(6'h20, 2'b10, 16'h0);
        nop(16'h0);
        nop(16'hABCD);
        rd_check(6'h20, 16'h11CD, "R5 lane0 only");
    endtask

    task automatic t_abort;
        write_word(6'h24, 16'h7777);
        write_word(6'h25, 16'h0000);
        ld_wr(6'h24, 2'b11, 16'h0);
        cont(2'b00, 1'b1, 16'h0);
        nop(16'hFFFF);
        nop(16'h5555);
        rd_check(6'h24, 16'h7777, "R6 aborted word unchanged");
        rd_check(6'h25, 16'h5555, "R6 burst advanced past abort");
    endtask

    task automatic t_dummy;
        ld_rd(6'h0A, 1'b1, 16'h0);
        cont(2'b11, 1'b0, 16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R7 dummy read slot");
        nop(16'h0);
        chk({31'd0, dq_oe}, 32'd1, "R7 next beat driven");
        chk({16'd0, dq_out}, 32'h0000B1B1, "R7 address advanced");
        nop(16'h0);
    endtask

    task automatic t_stall;
        write_word(6'h30, 16'h0000);
        ld_wr(6'h30, 2'b00, 16'h0);
        step(1'b1, SEL, 1'b0, 1'b1, 2'b00, 1'b0, 6'h31, 16'h9999);
        nop(16'h8888);
        nop(16'h3C3C);
        nop(16'h0);
        rd_check(6'h30, 16'h3C3C, "R2 write data delayed by stall");
        ld_rd(6'h30, 1'b0, 16'h0);
        step(1'b1, DES, 1'b0, 1'b1, 2'b11, 1'b1, 6'h0, 16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R2 stalled read not yet out");
        nop(16'h0);
        chk({31'd0, dq_oe}, 32'd1, "R2 read out after enabled edge");
        step(1'b1, DES, 1'b0, 1'b1, 2'b11, 1'b1, 6'h0, 16'h0);
        chk({31'd0, dq_oe}, 32'd1, "R2 oe held in stall");
        chk({16'd0, dq_out}, 32'h00003C3C, "R2 data held in stall");
        nop(16'h0);
        nop(16'h0);
    endtask

    task automatic t_continue;
        ld_rd(6'h08, 1'b0, 16'h0);
        step(1'b0, DES, 1'b1, 1'b0, 2'b00, 1'b0, 6'h3F, 16'h0);
        chk({16'd0, dq_out}, 32'h0000C2C2, "R8 first beat");
        nop(16'h9999);
        chk({31'd0, dq_oe}, 32'd1, "R8 continue stayed a read");
        chk({16'd0, dq_out}, 32'h0000D3D3, "R8 continue read 0x09");
        nop(16'h0);
        rd_check(6'h09, 16'hD3D3, "R8 rw_n ignored no write");
    endtask

    task automatic t_turnaround;
        write_word(6'h3A, 16'h1234);
        write_word(6'h3B, 16'h0000);
        ld_wr(6'h3A, 2'b01, 16'h0);
        ld_rd(6'h3A, 1'b0, 16'h0);
        ld_wr(6'h3B, 2'b00, 16'hAB00);
        chk({31'd0, dq_oe}, 32'd1, "R11 read right after write");
        chk({16'd0, dq_out}, 32'h0000AB34, "R11 merged forward");
        ld_rd(6'h3B, 1'b0, 16'h0);
        chk({31'd0, dq_oe}, 32'd0, "R11 write slot not driven");
        nop(16'h5A5A);
        chk({16'd0, dq_out}, 32'h00005A5A, "R11 full forward");
        nop(16'h0);
        rd_check(6'h3A, 16'hAB34, "R11 stored merge");
    endtask

    initial begin
        rst = 1'b1; mode = 1'b0;
        cke_n = 1'b0; {ce1_n, ce2, ce3_n} = DES; adv = 1'b0; rw_n = 1'b1;
        bw_n = 2'b11; oe_n = 1'b1; addr = '0; dq_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_linear();
        t_interleave();
        t_deselect();
        t_bytes();
        t_abort();
        t_dummy();
        t_stall();
        t_continue();
        t_turnaround();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule